// File: doc/BRIEF.md
# Bus Arbitration Phase Controller

This block runs the contention step of a parallel peripheral bus for one device whose identity is a 3-bit number. A requester raises `arb_req`. The block then waits for the bus to go free, respecting a minimum settle time and a maximum lateness. It drives its busy line together with the one data line that matches its identity, and waits out the contention window. It then reads the data lines to see whether a device of higher rank is also contending.

On a win it raises its select line and holds every drive unchanged for a fixed handoff time, then reports `won`. On a loss it lets go of every line and pulses `lost`. If the request is still up, it retries on the next bus-free phase.

All time limits are parameters in nanoseconds. They are turned into clock cycles by rounding up against the clock frequency parameter. Bus-free detection and the selection step that follows a win belong to other logic. The inputs here are already synchronised samples.

Top module: `arb_phase_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `bsy_oe`, `sel_oe`, `db_oe`, `dbp_oe`, `won` and `lost` are all 0.
- R2: With `arb_req` high, the first assertion of `bsy_oe` comes exactly FREE_CYC+1 cycles after the clock edge that first samples `bus_free` high following a low sample. FREE_CYC is ceil(FREE_NS·CLK_HZ/1e9), which is 100 at the defaults.
- R3: If `bus_free` was last sampled high SET_CYC or more cycles before the block would assert, the block does not assert at all. SET_CYC is 225 at the defaults. It waits for a fresh low-to-high change of `bus_free`. A request raised while a recent bus-free phase is still within its window asserts two cycles after `arb_req` is sampled.
- R4: While `bsy_oe` is 1, `db_oe` has exactly bit `own_id` set (bit n drives data line n) and `dbp_oe` is 1. `dbp_oe` means "drive parity true". While `bsy_oe` is 0, both `db_oe` and `dbp_oe` are 0.
- R5: The data lines are sampled exactly ARB_CYC cycles after `bsy_oe` first rises, and the outcome appears on the outputs at that edge. ARB_CYC is 300 at the defaults. Until then `sel_oe` and `lost` stay 0 and `bsy_oe` stays 1.
- R6: The block loses if any `db_in` bit with an index greater than `own_id` is 1 at the sampling edge. Bits at or below `own_id` have no effect on the outcome.
- R7: On a loss, `bsy_oe`, `db_oe` and `dbp_oe` drop to 0 and `lost` is 1 for exactly one cycle. If `arb_req` remains high, the block asserts again only after a new bus-free detection.
- R8: On a win, `sel_oe` rises while `bsy_oe` and the own `db_oe` bit stay 1.
- R9: If `sel_in` is sampled 1 while arbitrating and before the outcome, all drives are released in the next cycle and `lost` pulses. This is well inside CLEAR_CYC (100 cycles).
- R10: After `sel_oe` rises, every drive is held unchanged and `won` stays 0 for HOLD_CYC cycles (150 at the defaults). `won` then goes to 1. Deasserting `arb_req` during this hold has no effect.
- R11: Deasserting `arb_req` before the outcome releases all drives in the next cycle, with `lost` and `won` both 0.
- R12: After `won`, dropping `arb_req` releases all drives and clears `won` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_id | input | 3 | Identity of this device, held stable while requesting |
| arb_req | input | 1 | Request to contend for the bus |
| bus_free | input | 1 | Sampled bus-free indication |
| db_in | input | 8 | Sampled data lines, bit n is line n |
| sel_in | input | 1 | Sampled select line |
| bsy_oe | output | 1 | Drive the busy line |
| sel_oe | output | 1 | Drive the select line |
| db_oe | output | 8 | Per-line data drive enables |
| dbp_oe | output | 1 | Drive the parity line true |
| won | output | 1 | Contention won and handoff time elapsed |
| lost | output | 1 | One-cycle pulse on a loss |

## Verification
Every result is tied to a known clock edge. `bsy_oe` appears FREE_CYC+1 edges after the bus-free detection edge. The outcome appears ARB_CYC edges after `bsy_oe` first shows. `won` appears HOLD_CYC edges after `sel_oe`. Releases caused by `sel_in` or by withdrawing the request show one edge after the input is sampled. The bench drives and samples only on falling edges. It counts falling edges from each trigger, checks one cycle before each due point that the output has not yet moved, and checks on the due cycle that it has.

// File: rtl/arb_pkg.sv
// Shared types and helpers for the arbitration controller.
// Assumes delays are given in nanoseconds and the clock in hertz.
package arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ARB,
        ST_HOLD,
        ST_DONE,
        ST_LOST
    } arb_state_t;

    // Convert a delay in ns to clock cycles, rounding up.
    function automatic int ns_to_cycles(input longint ns, input longint clk_hz);
        longint prod;
        longint per_s;
        per_s = 64'sd1_000_000_000;
        prod  = ns * clk_hz;
        return int'((prod + per_s - 64'sd1) / per_s);
    endfunction

    // Bits needed to hold values 0..maxval.
    function automatic int cnt_width(input int maxval);
        return (maxval < 1) ? 1 : $clog2(maxval + 1);
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/arb_bus_free_timer.sv
// Tracks how long ago the bus went free and how long ago it was last seen free.
// Raises ready once the settle time has passed since a fresh free detection,
// while the lateness limit since the last free sample has not yet run out.
// Assumes bus_free is already synchronised. A detection is a low-to-high change.
// consume discards the current detection, so the next try needs a new one.
module arb_bus_free_timer
    import arb_pkg::*;
#(
    parameter int FREE_CYC = 100,
    parameter int SET_CYC  = 225
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_free,
    input  logic consume,
    output logic ready
);

    localparam int TFW = cnt_width(FREE_CYC);
    localparam int TLW = cnt_width(SET_CYC);
    localparam logic [TFW-1:0] TF_MAX = TFW'(FREE_CYC);
    localparam logic [TLW-1:0] TL_MAX = TLW'(SET_CYC);

    logic [TFW-1:0] since_rise_q;
    logic [TLW-1:0] since_high_q;
    logic           seen_q;
    logic           prev_q;
    logic           rise;

    assign rise = bus_free && !prev_q;

    // Age counters and the detection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q       <= 1'b0;
            since_rise_q <= '0;
            since_high_q <= TL_MAX;
            seen_q       <= 1'b0;
        end else begin
            prev_q <= bus_free;
            if (rise) begin
                since_rise_q <= '0;
            end else if (since_rise_q != TF_MAX) begin
                since_rise_q <= since_rise_q + 1'b1;
            end
            if (bus_free) begin
                since_high_q <= '0;
            end else if (since_high_q != TL_MAX) begin
                since_high_q <= since_high_q + 1'b1;
            end
            if (consume) begin
                seen_q <= 1'b0;
            end else if (rise) begin
                seen_q <= 1'b1;
            end else if (since_high_q == TL_MAX) begin
                seen_q <= 1'b0;
            end
        end
    end

    // Window open: settled long enough and not yet too late.
    always_comb begin
        ready = seen_q && (since_rise_q == TF_MAX) && (since_high_q < TL_MAX);
    end

    // R3: a consumed detection never leaves the window open in the next cycle.
    p_consume_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !ready);

endmodule

// File: rtl/arb_step_counter.sv
// Counts cycles spent in the current controller state and saturates at MAX_CNT.
// restart is raised on the edge where the state changes, so the count is 0 in
// the first cycle of each new state.
module arb_step_counter
    import arb_pkg::*;
#(
    parameter int MAX_CNT = 300,
    localparam int CW = cnt_width(MAX_CNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] CNT_TOP = CW'(MAX_CNT);

    // Cycle counter, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (count != CNT_TOP) begin
            count <= count + 1'b1;
        end
    end

    // The count never passes its ceiling.
    p_count_capped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_TOP);

endmodule

// File: rtl/arb_prio_cmp.sv
// Reports whether any data line of higher rank than own_id is active.
// Rank rises with line index. Lines at or below own_id are not looked at.
module arb_prio_cmp #(
    parameter int DBW = 8,
    localparam int IDW = $clog2(DBW)
) (
    input  logic [DBW-1:0] db_in,
    input  logic [IDW-1:0] own_id,
    output logic           higher
);

    logic [DBW-1:0] above;

    // One qualifier per line: active and ranked above this device.
    for (genvar i = 0; i < DBW; i++) begin : g_line
        assign above[i] = db_in[i] && (IDW'(i) > own_id);
    end

    // Any qualifying line means a loss.
    always_comb begin
        higher = |above;
    end

endmodule

// File: rtl/arb_phase_ctrl.sv
// Arbitration step controller for one device on a shared parallel bus.
// Waits for a fresh bus-free phase, drives busy plus its own data line, waits
// out the contention window, then wins (select, hold, won) or loses (release,
// lost pulse). Assumes all inputs are synchronised and own_id is stable while
// arb_req is high. Synchronous active-low reset.
module arb_phase_ctrl
    import arb_pkg::*;
#(
    parameter int CLK_HZ   = 125_000_000,
    parameter int FREE_NS  = 800,
    parameter int SET_NS   = 1800,
    parameter int ARB_NS   = 2400,
    parameter int CLEAR_NS = 800,
    parameter int HOLD_NS  = 1200,
    parameter int DBW      = 8,
    localparam int IDW     = $clog2(DBW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IDW-1:0] own_id,
    input  logic           arb_req,
    input  logic           bus_free,
    input  logic [DBW-1:0] db_in,
    input  logic           sel_in,
    output logic           bsy_oe,
    output logic           sel_oe,
    output logic [DBW-1:0] db_oe,
    output logic           dbp_oe,
    output logic           won,
    output logic           lost
);

    localparam int FREE_CYC  = ns_to_cycles(longint'(FREE_NS),  longint'(CLK_HZ));
    localparam int SET_CYC   = ns_to_cycles(longint'(SET_NS),   longint'(CLK_HZ));
    localparam int ARB_CYC   = ns_to_cycles(longint'(ARB_NS),   longint'(CLK_HZ));
    localparam int CLEAR_CYC = ns_to_cycles(longint'(CLEAR_NS), longint'(CLK_HZ));
    localparam int HOLD_CYC  = ns_to_cycles(longint'(HOLD_NS),  longint'(CLK_HZ));
    localparam int STEP_MAX  = imax(ARB_CYC, HOLD_CYC);
    localparam int SW        = cnt_width(STEP_MAX);
    localparam logic [SW-1:0] ARB_LAST  = SW'(ARB_CYC - 1);
    localparam logic [SW-1:0] HOLD_LAST = SW'(HOLD_CYC - 1);
    localparam int RW        = cnt_width(CLEAR_CYC + 1);
    localparam logic [RW-1:0] REL_TOP   = RW'(CLEAR_CYC + 1);
    localparam logic [RW-1:0] REL_LIM   = RW'(CLEAR_CYC);

    arb_state_t    state_q;
    arb_state_t    state_d;
    logic          free_ready;
    logic          consume;
    logic          higher;
    logic [SW-1:0] step_cnt;
    logic          arb_done;
    logic          hold_done;
    logic          drive;

    // Bus-free age tracking.
    arb_bus_free_timer #(
        .FREE_CYC (FREE_CYC),
        .SET_CYC  (SET_CYC)
    ) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_free (bus_free),
        .consume  (consume),
        .ready    (free_ready)
    );

    // Time spent in the current state.
    arb_step_counter #(
        .MAX_CNT (STEP_MAX)
    ) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .count   (step_cnt)
    );

    // Rank comparison against the sampled data lines.
    arb_prio_cmp #(
        .DBW (DBW)
    ) u_prio (
        .db_in  (db_in),
        .own_id (own_id),
        .higher (higher)
    );

    // Window end flags.
    always_comb begin
        arb_done  = (step_cnt >= ARB_LAST);
        hold_done = (step_cnt >= HOLD_LAST);
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (arb_req) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!arb_req)        state_d = ST_IDLE;
                else if (free_ready) state_d = ST_ARB;
            end
            ST_ARB: begin
                if (!arb_req)      state_d = ST_IDLE;
                else if (sel_in)   state_d = ST_LOST;
                else if (arb_done) state_d = higher ? ST_LOST : ST_HOLD;
            end
            ST_HOLD: if (hold_done) state_d = ST_DONE;
            ST_DONE: if (!arb_req)  state_d = ST_IDLE;
            ST_LOST: state_d = arb_req ? ST_WAIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the current state.
    always_comb begin
        drive   = (state_q == ST_ARB) || (state_q == ST_HOLD) || (state_q == ST_DONE);
        consume = drive || (state_q == ST_LOST);
        bsy_oe  = drive;
        dbp_oe  = drive;
        sel_oe  = (state_q == ST_HOLD) || (state_q == ST_DONE);
        won     = (state_q == ST_DONE);
        lost    = (state_q == ST_LOST);
        db_oe   = drive ? (DBW'(1) << own_id) : '0;
    end

    // Cycles a foreign select has been seen while still contending.
    logic [RW-1:0] rel_wait_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_wait_q <= '0;
        end else if (sel_in && bsy_oe && !sel_oe) begin
            if (rel_wait_q != REL_TOP) rel_wait_q <= rel_wait_q + 1'b1;
        end else begin
            rel_wait_q <= '0;
        end
    end

    p_bsy_after_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_oe) |-> $past(free_ready));

    p_one_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(db_oe) <= 1);

    p_line_with_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (db_oe != '0) == bsy_oe);

    p_parity_with_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dbp_oe |-> bsy_oe);

    p_sel_after_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_oe) |-> $past(arb_done));

    p_lost_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> (!bsy_oe && !sel_oe && db_oe == '0));

    p_sel_keeps_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_oe |-> bsy_oe);

    p_foreign_sel_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_wait_q <= REL_LIM);

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oe && !won) |=> (sel_oe && bsy_oe && $stable(db_oe)));

    p_won_with_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        won |-> sel_oe);

endmodule

// File: tb/sim_arb_phase_ctrl.sv
`timescale 1ns/1ps
module sim_arb_phase_ctrl;

    function automatic int to_cyc(input longint ns);
        return int'((ns * 64'sd125_000_000 + 64'sd999_999_999) / 64'sd1_000_000_000);
    endfunction

    localparam int FREE_C = to_cyc(800);
    localparam int SET_C  = to_cyc(1800);
    localparam int ARB_C  = to_cyc(2400);
    localparam int HOLD_C = to_cyc(1200);

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] own_id;
    logic       arb_req, bus_free, sel_in;
    logic [7:0] db_in;
    logic       bsy_oe, sel_oe, dbp_oe, won, lost;
    logic [7:0] db_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    arb_phase_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .own_id(own_id), .arb_req(arb_req),
        .bus_free(bus_free), .db_in(db_in), .sel_in(sel_in),
        .bsy_oe(bsy_oe), .sel_oe(sel_oe), .db_oe(db_oe), .dbp_oe(dbp_oe),
        .won(won), .lost(lost)
    );

    function automatic bit exp_lose(input logic [7:0] db, input logic [2:0] id);
        bit r = 1'b0;
        for (int i = 0; i < 8; i++) if (i > int'(id) && db[i]) r = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] own_line(input logic [2:0] id);
        return 8'(1) << id;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic released(input string tag);
        chk(!bsy_oe && !sel_oe && db_oe == 8'h00 && !dbp_oe, tag,
            {bsy_oe, sel_oe, dbp_oe, db_oe}, 0);
    endtask

    // Fresh bus-free pulse with request high; ends on the first busy cycle.
    task automatic arm(input logic [2:0] id);
        own_id   = id;
        arb_req  = 1'b1;
        bus_free = 1'b1;
        step();
        bus_free = 1'b0;
        repeat (FREE_C) step();
        chk(!bsy_oe, "R2 busy early", bsy_oe, 0);
        step();
        chk(bsy_oe, "R2 busy due", bsy_oe, 1);
        chk(db_oe == own_line(id) && dbp_oe, "R4 own line", db_oe, own_line(id));
    endtask

    // From the first busy cycle to the outcome; returns 1 on a win.
    task automatic decide(input logic [7:0] db, output bit win);
        bit el;
        el    = exp_lose(db, own_id);
        db_in = db;
        repeat (ARB_C - 1) step();
        chk(bsy_oe && !sel_oe && !lost, "R5 before outcome", {bsy_oe, sel_oe, lost}, 4);
        step();
        if (el) begin
            chk(lost && !bsy_oe && db_oe == 8'h00 && !dbp_oe, "R6 R7 loss", {lost, bsy_oe}, 2);
            step();
            chk(!lost, "R7 lost pulse", lost, 0);
        end else begin
            chk(sel_oe && bsy_oe && db_oe == own_line(own_id), "R6 R8 win", {sel_oe, bsy_oe}, 3);
        end
        win   = !el;
        db_in = 8'h00;
    endtask

    // From the first select cycle through won and release.
    task automatic finish_win(input bit drop_early);
        if (drop_early) begin
            repeat (HOLD_C / 3) step();
            arb_req = 1'b0;
            repeat (HOLD_C - 1 - HOLD_C / 3) step();
        end else begin
            repeat (HOLD_C - 1) step();
        end
        chk(!won && sel_oe && bsy_oe && db_oe == own_line(own_id), "R10 hold", won, 0);
        step();
        chk(won && sel_oe, "R10 won due", won, 1);
        arb_req = 1'b0;
        step();
        chk(!won, "R12 won cleared", won, 0);
        released("R12 release");
    endtask

    initial begin
        bit win;
        bit seen_hi;
        int unsigned seed_v;
        seed_v = $urandom(32'd24681357);
        rst_n = 1'b0; own_id = 3'd3; arb_req = 1'b0; bus_free = 1'b0;
        sel_in = 1'b0; db_in = 8'h00;
        repeat (3) step();
        arb_req = 1'b1;
        step();
        released("R1 in reset");
        chk(!won && !lost, "R1 status in reset", {won, lost}, 0);
        arb_req = 1'b0;
        rst_n = 1'b1;
        step();
        released("R1 after reset");

        // Lone contender wins, request dropped during the hold.
        arm(3'd3);
        decide(8'h08, win);
        finish_win(1'b1);
        step();

        // Highest-rank device ignores all lower lines.
        arm(3'd7);
        decide(8'hFF, win);
        finish_win(1'b0);
        step();

        // Lowest rank loses to line 7, then retries only after a new free phase (R7).
        arm(3'd0);
        decide(8'h81, win);
        seen_hi = 1'b0;
        repeat (200) begin step(); if (bsy_oe) seen_hi = 1'b1; end
        chk(!seen_hi, "R7 no retry without free", seen_hi, 0);
        arm(3'd0);
        decide(8'h01, win);
        finish_win(1'b0);
        step();

        // Stale bus-free: request raised after the lateness limit (R3).
        bus_free = 1'b1; step(); bus_free = 1'b0;
        repeat (SET_C + 15) step();
        arb_req = 1'b1; own_id = 3'd5;
        seen_hi = 1'b0;
        repeat (400) begin step(); if (bsy_oe) seen_hi = 1'b1; end
        chk(!seen_hi, "R3 stale no assert", seen_hi, 0);
        arm(3'd5);
        decide(8'h20, win);
        finish_win(1'b0);
        step();

        // Recent bus-free: request raised inside the window (R3).
        bus_free = 1'b1; step(); bus_free = 1'b0;
        repeat (FREE_C + 49) step();
        arb_req = 1'b1; own_id = 3'd2;
        step();
        chk(!bsy_oe, "R3 late request early", bsy_oe, 0);
        step();
        chk(bsy_oe && db_oe == own_line(3'd2), "R3 late request due", bsy_oe, 1);
        decide(8'h04, win);
        finish_win(1'b0);
        step();

        // Foreign select during contention (R9).
        arm(3'd6);
        repeat (10) step();
        sel_in = 1'b1;
        step();
        chk(!bsy_oe && lost, "R9 foreign sel", {bsy_oe, lost}, 1);
        sel_in = 1'b0; arb_req = 1'b0;
        step();
        released("R9 stays released");

        // Withdrawal before the outcome (R11).
        arm(3'd1);
        repeat (ARB_C - 2) step();
        arb_req = 1'b0;
        step();
        chk(!bsy_oe && !lost && !won, "R11 withdraw", {bsy_oe, lost, won}, 0);
        step();
        chk(!lost, "R11 no lost later", lost, 0);

        // Random trials.
        for (int t = 0; t < 24; t++) begin
            logic [2:0] id;
            logic [7:0] db;
            int kind;
            int k;
            id   = 3'($urandom_range(0, 7));
            db   = 8'($urandom_range(0, 255)) | own_line(id);
            kind = $urandom_range(0, 3);
            k    = $urandom_range(1, ARB_C - 10);
            step();
            arm(id);
            if (kind == 2) begin
                repeat (k) step();
                sel_in = 1'b1;
                step();
                chk(!bsy_oe && lost, "R9 random foreign sel", {bsy_oe, lost}, 1);
                sel_in = 1'b0; arb_req = 1'b0;
                step();
            end else if (kind == 3) begin
                repeat (k) step();
                arb_req = 1'b0;
                step();
                chk(!bsy_oe && !lost, "R11 random withdraw", {bsy_oe, lost}, 0);
                step();
            end else begin
                decide(db, win);
                if (win) finish_win(kind == 1);
                else arb_req = 1'b0;
                step();
            end
            released("R7 random idle");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule